// File: doc/BRIEF.md
# Lease-Timed L1 Data Cache

This block is a small direct-mapped first-level data cache for a single GPU core. It keeps coherence through leases instead of messages. Each line holds a tag, one data word and an expiry timestamp. A common global time value is fed into every core. A line can serve a load only while its stored expiry is later than that time. Once the global time reaches the expiry, the line simply stops hitting. Nothing is ever invalidated, recalled or acknowledged.

A load that cannot be served sends one read to the next level and names the lifetime it would like. The next level answers with a fill carrying the data and the expiry it grants. The cache installs both and completes the load. Stores never take ownership. Each store is forwarded to the next level and completes when that level accepts it. A store whose line is currently live also refreshes the local copy. Only one miss or store is outstanding at a time, and the core interface stalls until it finishes.

Top module: `lease_l1_cache`

## Requirements
- R1: A load accepted while its line is present, the tag matches and the stored expiry is strictly greater than `gtime` is a hit. `rsp_valid` is high in the next cycle with the cached word, and no next-level request is raised. An expiry equal to `gtime` counts as a miss.
- R2: A load miss raises `l2_req_valid` in the cycle after acceptance, with `l2_req_write`=0, the load address and `l2_req_lifetime` equal to the LIFETIME parameter. Address, write flag and lifetime are held until `l2_req_ready` is seen.
- R3: After the read is accepted, a `fill_valid` pulse installs the tag, `fill_data` and `fill_expiry` into the line. `rsp_valid` is high in the next cycle with `fill_data`.
- R4: Every accepted store raises `l2_req_valid` in the next cycle, whether it hits or misses. The request carries `l2_req_write`=1, the address, the store data and `l2_req_lifetime`=0. `rsp_valid` pulses in the cycle after the next level accepts it.
- R5: A store to a live line replaces the cached word and leaves the expiry unchanged. A store that misses allocates nothing, so any line already present keeps its contents.
- R6: While a miss or a store is outstanding, `req_ready` is low, so at most one miss is in flight.
- R7: After reset, `req_ready`=1, `l2_req_valid`=0 and `rsp_valid`=0, and no line is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtime | input | TS_W | Shared global time, non-decreasing |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address (low IDX_W bits select the line) |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Load result |
| l2_req_valid | output | 1 | Next-level request valid |
| l2_req_ready | input | 1 | Next level accepts the request |
| l2_req_write | output | 1 | 1 = write-through, 0 = read |
| l2_req_addr | output | ADDR_W | Request address |
| l2_req_wdata | output | DATA_W | Write-through data |
| l2_req_lifetime | output | TS_W | Requested lease length (0 on writes) |
| fill_valid | input | 1 | Fill response valid |
| fill_data | input | DATA_W | Fill word |
| fill_expiry | input | TS_W | Granted expiry timestamp |

## Verification
The bench builds the cache with 4 lines, 5-bit addresses and a lifetime of 12. With so few lines and addresses, random traffic keeps causing tag conflicts, and the global time overtakes leases within a few operations. Hits, expiries and conflict misses are therefore all common. The next level is modelled with random accept and fill delays, and it grants leases that sometimes differ from the request, including leases that are already expired. Directed cases place loads one tick before and exactly at an expiry, and check stores that hit and stores that miss.

// File: rtl/l1l_pkg.sv
package l1l_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_SEND = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_SEND = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/l1l_line_store.sv
module l1l_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_present,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  output logic [TS_W-1:0]   rd_exp,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              data_we,
  input  logic              meta_we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TS_W-1:0]   wr_exp
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   line_sel;
  logic [SETS-1:0]   present_q;
  logic [SETS-1:0]   present_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];
  logic [TS_W-1:0]   exp_q  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    assign line_sel[g]  = (wr_idx == IDX_W'(g));
    assign present_d[g] = present_q[g] | (meta_we & line_sel[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else        present_q <= present_d;
  end

  always_ff @(posedge clk) begin
    if (data_we) data_q[wr_idx] <= wr_data;
    if (meta_we) begin
      tag_q[wr_idx] <= wr_tag;
      exp_q[wr_idx] <= wr_exp;
    end
  end

  assign rd_present = present_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_data    = data_q[rd_idx];
  assign rd_exp     = exp_q[rd_idx];
endmodule

// File: rtl/l1l_lease_check.sv
module l1l_lease_check #(
  parameter int TAG_W = 7,
  parameter int TS_W  = 32
) (
  input  logic             present,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] want_tag,
  input  logic [TS_W-1:0]  line_exp,
  input  logic [TS_W-1:0]  gtime,
  output logic             live
);
  // strictly later than now; unsigned, no wrap handling
  assign live = present && (line_tag == want_tag) && (line_exp > gtime);
endmodule

// File: rtl/l1l_ctrl.sv
module l1l_ctrl
  import l1l_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic hit,
  input  logic l2_ready,
  input  logic fill_valid,
  output logic req_ready,
  output logic accept,
  output logic rd_send,
  output logic wr_send,
  output logic store_we,
  output logic fill_we,
  output logic rsp_hit,
  output logic rsp_store
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (accept) state_d = req_write ? ST_WR_SEND : (hit ? ST_IDLE : ST_RD_SEND);
      ST_RD_SEND: if (l2_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (fill_valid) state_d = ST_IDLE;
      ST_WR_SEND: if (l2_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_send   = (state_q == ST_RD_SEND);
  assign wr_send   = (state_q == ST_WR_SEND);
  assign store_we  = accept && req_write && hit;
  assign fill_we   = (state_q == ST_RD_WAIT) && fill_valid;
  assign rsp_hit   = accept && !req_write && hit;
  assign rsp_store = wr_send && l2_ready;

  // R6
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && !hit) |=> !req_ready);

  // R6
  wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RD_WAIT) && !fill_valid) |=> !req_ready);
endmodule

// File: rtl/lease_l1_cache.sv
module lease_l1_cache #(
  parameter int ADDR_W   = 10,
  parameter int IDX_W    = 3,
  parameter int DATA_W   = 32,
  parameter int TS_W     = 32,
  parameter int LIFETIME = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   gtime,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              l2_req_valid,
  input  logic              l2_req_ready,
  output logic              l2_req_write,
  output logic [ADDR_W-1:0] l2_req_addr,
  output logic [DATA_W-1:0] l2_req_wdata,
  output logic [TS_W-1:0]   l2_req_lifetime,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [TS_W-1:0]   fill_expiry
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              accept, hit, rd_send, wr_send;
  logic              store_we, fill_we, rsp_hit, rsp_store;
  logic              rd_present;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic [TS_W-1:0]   rd_exp;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  l1l_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .hit        (hit),
    .l2_ready   (l2_req_ready),
    .fill_valid (fill_valid),
    .req_ready  (req_ready),
    .accept     (accept),
    .rd_send    (rd_send),
    .wr_send    (wr_send),
    .store_we   (store_we),
    .fill_we    (fill_we),
    .rsp_hit    (rsp_hit),
    .rsp_store  (rsp_store)
  );

  // fill writes the latched miss line; store hit writes the incoming line
  assign wr_idx  = fill_we ? addr_q[IDX_W-1:0] : req_addr[IDX_W-1:0];
  assign wr_data = fill_we ? fill_data : req_wdata;

  l1l_line_store #(
    .IDX_W (IDX_W), .TAG_W (TAG_W), .DATA_W (DATA_W), .TS_W (TS_W)
  ) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (req_addr[IDX_W-1:0]),
    .rd_present (rd_present),
    .rd_tag     (rd_tag),
    .rd_data    (rd_data),
    .rd_exp     (rd_exp),
    .wr_idx     (wr_idx),
    .data_we    (fill_we | store_we),
    .meta_we    (fill_we),
    .wr_tag     (addr_q[ADDR_W-1:IDX_W]),
    .wr_data    (wr_data),
    .wr_exp     (fill_expiry)
  );

  l1l_lease_check #(.TAG_W (TAG_W), .TS_W (TS_W)) u_lease (
    .present  (rd_present),
    .line_tag (rd_tag),
    .want_tag (req_addr[ADDR_W-1:IDX_W]),
    .line_exp (rd_exp),
    .gtime    (gtime),
    .live     (hit)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    rsp_valid_d = rsp_hit | fill_we | rsp_store;
    rsp_data_d  = rsp_data_q;
    if (rsp_hit)      rsp_data_d = rd_data;
    else if (fill_we) rsp_data_d = fill_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  assign rsp_valid       = rsp_valid_q;
  assign rsp_data        = rsp_data_q;
  assign l2_req_valid    = rd_send | wr_send;
  assign l2_req_write    = wr_send;
  assign l2_req_addr     = addr_q;
  assign l2_req_wdata    = wdata_q;
  assign l2_req_lifetime = wr_send ? '0 : TS_W'(LIFETIME);

  // R1
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write && hit) |=> (rsp_valid && !l2_req_valid));

  // R2
  l2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && !l2_req_ready) |=>
      (l2_req_valid && $stable(l2_req_addr) && $stable(l2_req_write) && $stable(l2_req_lifetime)));

  // R3
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (rsp_valid && rsp_data == $past(fill_data)));

  // R4
  store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (l2_req_valid && l2_req_write && l2_req_lifetime == '0));
endmodule

// File: tb/lease_l1_cache_test.sv
module lease_l1_cache_test;
  localparam int AW = 5;
  localparam int IW = 2;
  localparam int DW = 32;
  localparam int TW = 32;
  localparam int LT = 12;
  localparam int NL = 1 << IW;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] gtime;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          l2_req_valid, l2_req_ready, l2_req_write;
  logic [AW-1:0] l2_req_addr;
  logic [DW-1:0] l2_req_wdata;
  logic [TW-1:0] l2_req_lifetime;
  logic          fill_valid;
  logic [DW-1:0] fill_data;
  logic [TW-1:0] fill_expiry;

  int nchk = 0;
  int nerr = 0;

  bit            m_val [NL];
  logic [AW-IW-1:0] m_tag [NL];
  logic [TW-1:0] m_exp [NL];
  logic [DW-1:0] mem   [NW];

  always #10 clk = ~clk;

  lease_l1_cache #(
    .ADDR_W (AW), .IDX_W (IW), .DATA_W (DW), .TS_W (TW), .LIFETIME (LT)
  ) uut (
    .clk (clk), .rst_n (rst_n), .gtime (gtime),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .l2_req_valid (l2_req_valid), .l2_req_ready (l2_req_ready),
    .l2_req_write (l2_req_write), .l2_req_addr (l2_req_addr),
    .l2_req_wdata (l2_req_wdata), .l2_req_lifetime (l2_req_lifetime),
    .fill_valid (fill_valid), .fill_data (fill_data), .fill_expiry (fill_expiry)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a, input logic [TW-1:0] t);
    int i = int'(a[IW-1:0]);
    return m_val[i] && (m_tag[i] == a[AW-1:IW]) && (m_exp[i] > t);
  endfunction

  // next level accepts after a random delay; cache must hold and stall (R2, R6)
  task automatic l2_accept(input logic [AW-1:0] a, input bit wr);
    int d = int'($urandom % 4);
    for (int k = 0; k < d; k++) begin
      @(posedge clk); @(negedge clk);
      chk(l2_req_valid && l2_req_addr == a && l2_req_write == wr, "R2 hold", {63'd0, l2_req_valid}, 64'd1);
      chk(!req_ready, "R6 stall", {63'd0, req_ready}, 64'd0);
    end
    l2_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    l2_req_ready = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input int grant, input string tag);
    bit eh = model_hit(a, gtime);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (eh) begin
      chk(rsp_valid && !l2_req_valid, {"R1 hit ", tag}, {62'd0, rsp_valid, l2_req_valid}, 64'd2);
      chk(rsp_data == mem[a], {"R1 data ", tag}, 64'(rsp_data), 64'(mem[a]));
    end else begin
      chk(l2_req_valid && !l2_req_write && !rsp_valid, {"R2 miss ", tag},
          {61'd0, l2_req_valid, l2_req_write, rsp_valid}, 64'd4);
      chk(l2_req_addr == a && l2_req_lifetime == TW'(LT), {"R2 fields ", tag},
          {27'd0, l2_req_addr, l2_req_lifetime}, {27'd0, a, 32'(LT)});
      l2_accept(a, 1'b0);
      for (int k = 0; k < int'($urandom % 3); k++) begin
        chk(!req_ready && !rsp_valid, "R6 wait", {62'd0, req_ready, rsp_valid}, 64'd0);
        @(posedge clk); @(negedge clk);
      end
      fill_valid = 1'b1; fill_data = mem[a]; fill_expiry = gtime + TW'(grant);
      @(posedge clk); @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid && rsp_data == mem[a], {"R3 fill ", tag}, 64'(rsp_data), 64'(mem[a]));
      chk(req_ready, "R6 release", {63'd0, req_ready}, 64'd1);
      m_val[int'(a[IW-1:0])] = 1'b1;
      m_tag[int'(a[IW-1:0])] = a[AW-1:IW];
      m_exp[int'(a[IW-1:0])] = gtime + TW'(grant);
    end
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] v, input string tag);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(l2_req_valid && l2_req_write && !rsp_valid, {"R4 fwd ", tag},
        {61'd0, l2_req_valid, l2_req_write, rsp_valid}, 64'd6);
    chk(l2_req_addr == a && l2_req_wdata == v && l2_req_lifetime == '0, {"R4 fields ", tag},
        {l2_req_wdata, l2_req_lifetime}, {v, 32'd0});
    l2_accept(a, 1'b1);
    chk(rsp_valid, {"R4 done ", tag}, {63'd0, rsp_valid}, 64'd1);
    mem[a] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; gtime = 32'd100;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    l2_req_ready = 1'b0; fill_valid = 1'b0; fill_data = '0; fill_expiry = '0;
    for (int i = 0; i < NL; i++) begin m_val[i] = 1'b0; m_tag[i] = '0; m_exp[i] = '0; end
    for (int i = 0; i < NW; i++) mem[i] = 32'hA000_0000 + 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(req_ready && !l2_req_valid && !rsp_valid, "R7 reset",
        {61'd0, req_ready, l2_req_valid, rsp_valid}, 64'd4);

    // R7: first access to a line misses
    do_load(5'd5, 10, "first");
    chk(m_exp[1] == 32'd110, "R3 expiry model", 64'(m_exp[1]), 64'd110);
    // R1 boundary: one tick before expiry hits, at expiry misses
    gtime = 32'd109; do_load(5'd5, 10, "before expiry");
    gtime = 32'd110;
    chk(!model_hit(5'd5, gtime), "R1 model", 64'd0, 64'd0);
    do_load(5'd5, 20, "at expiry");
    // R5: store hit updates local copy, then hit returns it
    gtime = 32'd112;
    do_store(5'd5, 32'hDEAD_0005, "hit");
    do_load(5'd5, 20, "after store hit");
    // R5: store miss on same line does not allocate; old line still hits
    do_store(5'd9, 32'hBEEF_0009, "miss");
    do_load(5'd5, 20, "no alloc");
    do_load(5'd9, 20, "conflict");
    // granted expiry equal to now is already stale (R1)
    gtime = 32'd140;
    do_load(5'd2, 0, "zero lease");
    do_load(5'd2, 5, "zero lease again");

    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      gtime = gtime + 32'($urandom % 4);
      a = AW'($urandom);
      if ($urandom % 10 < 7) do_load(a, ($urandom % 4 == 0) ? int'($urandom % 20) : LT, "rand");
      else do_store(a, $urandom, "rand");
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule